// File: doc/BRIEF.md
# PCI Type-0 Configuration Header

This block holds the 256-byte configuration header of a single-function PCI target that maps one memory window. Software reaches it through a plain register port: a dword index (0 to 63), four byte enables, write data, a write strobe and a read strobe. A read strobe captures the addressed dword, and it appears on the read data port one clock later. A write strobe updates the writable bytes of the addressed dword in the same edge.

The header mixes three kinds of storage. Identity and class fields are constants. The command word holds three writable control bits, which drive the memory-enable, parity-response and SERR-enable outputs. The status word has three sticky event bits, set by pulse inputs and cleared by writing ones. A single base address register decodes a 256-byte memory window, and its value is brought out for the address decoder. Dwords outside the header fields read as zero. Writes to them, and to constant fields, change nothing.

Top module: `pcfg_hdr`

## Requirements
- R1: Dword 0 reads {DEVICE_ID, VENDOR_ID}, with the device ID in bits 31:16. The default device ID is 16'h5A31 and the default vendor ID is 16'h1B2C. Neither value may be 0000h or FFFFh.
- R2: Dword 2 reads {24'h018000, REV_ID}, with the class code in bits 31:8. The default revision is 8'h01. Dword 3 reads 0, so the header type byte (bits 23:16) is 00h.
- R3: In dword 1, only command bits 1, 6 and 8 (dword bits 1, 6, 8) are writable, and all other command bits read 0. The mem_en, perr_resp and serr_en outputs follow bits 1, 6 and 8 from the clock edge after the write.
- R4: After reset, all three command bits are 0, the sticky status bits are 0 and the BAR is 0.
- R5: Status bits 10:9 (dword 1 bits 26:25) always read 01b, the code for medium device-select timing.
- R6: A one-cycle pulse on ev_tgt_abort sets status bit 11 (dword bit 27). A pulse on ev_sys_err sets bit 14 (dword bit 30). A pulse on ev_parity_err sets bit 15 (dword bit 31). Each bit stays set until it is cleared.
- R7: Writing 1 to a sticky status bit clears it, and writing 0 leaves it unchanged. If an event and a clear land on the same cycle, the bit stays set.
- R8: The BAR is dword 4, and its bits 7:0 always read 0. Bit 0 = 0 marks a memory mapping. Writing FFFFFFFFh reads back FFFFFF00h. Writing CD000000h makes the BAR and bar_base CD000000h.
- R9: Writes apply per byte lane: lane n (bits 8n+7:8n) changes only when cfg_be[n] is 1. This holds for command bits, status clears and BAR bytes.
- R10: Writes to dwords 0, 2 and 3, and to any dword from 5 to 63, have no effect. Dwords 5 to 63 read 0.
- R11: cfg_rdata takes the addressed dword on the clock edge where cfg_rd is 1. It keeps that value while cfg_rd is 0, and it resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_idx | input | 6 | Dword index into the header |
| cfg_be | input | 4 | Byte enables for writes |
| cfg_wdata | input | 32 | Write data |
| cfg_wr | input | 1 | Write strobe |
| cfg_rd | input | 1 | Read strobe |
| cfg_rdata | output | 32 | Registered read data |
| ev_tgt_abort | input | 1 | Target-abort event pulse |
| ev_sys_err | input | 1 | System-error event pulse |
| ev_parity_err | input | 1 | Parity-error event pulse |
| mem_en | output | 1 | Memory space enable (command bit 1) |
| perr_resp | output | 1 | Parity error response (command bit 6) |
| serr_en | output | 1 | SERR driver enable (command bit 8) |
| bar_base | output | 32 | Decoded memory base address |

## Verification
The bench writes all ones to the command word, to constant dwords and to the BAR. A design that leaks reserved command bits, overwrites identity fields or keeps low BAR bits would read back something other than the fixed mask values. The bench raises an event and a clear on the same cycle, and a design that lets the clear win would drop a status bit. It also writes zeros to set status bits and writes with partial byte enables, which catches a clear that ignores the written value or the lane. A read strobe followed by idle cycles with a changed index checks that read data is held rather than decoded on every cycle.

// File: rtl/pcfg_pkg.sv
package pcfg_pkg;
  localparam int unsigned DW_ID     = 0;
  localparam int unsigned DW_CMDSTS = 1;
  localparam int unsigned DW_CLASS  = 2;
  localparam int unsigned DW_HDR    = 3;
  localparam int unsigned DW_BAR    = 4;

  localparam logic [15:0] CMD_WMASK   = 16'h0142;
  localparam logic [15:0] STS_FIXED   = 16'h0200;
  localparam int unsigned N_STICKY    = 3;

  // status bit position of each sticky event: target abort, system error, parity error
  function automatic int unsigned sticky_pos(input int unsigned i);
    case (i)
      0:       return 11;
      1:       return 14;
      default: return 15;
    endcase
  endfunction

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[i*8 +: 8] = {8{be[i]}};
    return m;
  endfunction

  function automatic logic [31:0] merge_lanes(input logic [31:0] old_v,
                                              input logic [31:0] new_v,
                                              input logic [3:0]  be);
    logic [31:0] m;
    m = lane_mask(be);
    return (old_v & ~m) | (new_v & m);
  endfunction

  function automatic logic [31:0] bar_size_mask(input int unsigned size_log2);
    return ~((32'd1 << size_log2) - 32'd1);
  endfunction

  function automatic logic w1c_hit(input logic [31:0] wdata,
                                   input logic [3:0]  be,
                                   input int unsigned dw_bit);
    return be[dw_bit / 8] & wdata[dw_bit];
  endfunction
endpackage

// File: rtl/pcfg_cmd_reg.sv
module pcfg_cmd_reg
  import pcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [1:0]  be,
  input  logic [15:0] wdata,
  output logic [15:0] cmd
);
  logic [15:0] cmd_q;
  logic [15:0] cmd_nxt;

  always_comb begin
    cmd_nxt = cmd_q;
    if (wr_hit) cmd_nxt = merge_lanes({16'h0, cmd_q}, {16'h0, wdata}, {2'b00, be}) & {16'h0, CMD_WMASK};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_nxt;
  end

  assign cmd = cmd_q;

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(cmd_q));
  // R3
  cmd_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((cmd_q & ~CMD_WMASK) == 16'h0));
endmodule

// File: rtl/pcfg_status_reg.sv
module pcfg_status_reg
  import pcfg_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_STICKY-1:0] ev,
  input  logic [N_STICKY-1:0] clr,
  output logic [15:0]         sts
);
  logic [N_STICKY-1:0] stk_q;
  logic [15:0]         sts_w;

  for (genvar i = 0; i < N_STICKY; i++) begin : g_stk
    always_ff @(posedge clk) begin
      if (!rst_n)     stk_q[i] <= 1'b0;
      else if (ev[i]) stk_q[i] <= 1'b1;
      else if (clr[i]) stk_q[i] <= 1'b0;
    end

    // R6
    stk_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> stk_q[i]);
    // R7
    stk_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_q[i] && !clr[i]) |=> stk_q[i]);
  end

  always_comb begin
    sts_w = STS_FIXED;
    for (int i = 0; i < N_STICKY; i++) sts_w[sticky_pos(i)] = stk_q[i];
  end

  assign sts = sts_w;
endmodule

// File: rtl/pcfg_bar_reg.sv
module pcfg_bar_reg
  import pcfg_pkg::*;
#(
  parameter int unsigned SIZE_LOG2 = 8
)(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [3:0]  be,
  input  logic [31:0] wdata,
  output logic [31:0] bar
);
  localparam logic [31:0] SZ_MASK = bar_size_mask(SIZE_LOG2);

  logic [31:0] bar_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      bar_q <= '0;
    else if (wr_hit) bar_q <= merge_lanes(bar_q, wdata, be) & SZ_MASK;
  end

  assign bar = bar_q;

  // R8
  bar_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ((bar_q & ~SZ_MASK) == 32'h0));
  // R9
  bar_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hit && !be[3]) |=> (bar_q[31:24] == $past(bar_q[31:24])));
endmodule

// File: rtl/pcfg_hdr.sv
module pcfg_hdr
  import pcfg_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID  = 16'h1B2C,
  parameter logic [15:0] DEVICE_ID  = 16'h5A31,
  parameter logic [7:0]  REV_ID     = 8'h01,
  parameter logic [23:0] CLASS_CODE = 24'h018000,
  parameter int unsigned BAR_LOG2   = 8,
  parameter int unsigned IDX_W      = 6
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [3:0]       cfg_be,
  input  logic [31:0]      cfg_wdata,
  input  logic             cfg_wr,
  input  logic             cfg_rd,
  output logic [31:0]      cfg_rdata,
  input  logic             ev_tgt_abort,
  input  logic             ev_sys_err,
  input  logic             ev_parity_err,
  output logic             mem_en,
  output logic             perr_resp,
  output logic             serr_en,
  output logic [31:0]      bar_base
);
  logic [15:0]         cmd_w;
  logic [15:0]         sts_w;
  logic [31:0]         bar_w;
  logic                cmdsts_wr;
  logic                bar_wr;
  logic [N_STICKY-1:0] clr_req;
  logic [N_STICKY-1:0] ev_vec;
  logic [31:0]         rd_mux;
  logic [31:0]         rdata_q;

  assign cmdsts_wr = cfg_wr && (cfg_idx == IDX_W'(DW_CMDSTS));
  assign bar_wr    = cfg_wr && (cfg_idx == IDX_W'(DW_BAR));
  assign ev_vec    = {ev_parity_err, ev_sys_err, ev_tgt_abort};

  for (genvar i = 0; i < N_STICKY; i++) begin : g_clr
    assign clr_req[i] = cmdsts_wr && w1c_hit(cfg_wdata, cfg_be, 16 + sticky_pos(i));
  end

  pcfg_cmd_reg u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_hit(cmdsts_wr),
    .be(cfg_be[1:0]), .wdata(cfg_wdata[15:0]), .cmd(cmd_w)
  );

  pcfg_status_reg u_sts (
    .clk(clk), .rst_n(rst_n), .ev(ev_vec), .clr(clr_req), .sts(sts_w)
  );

  pcfg_bar_reg #(.SIZE_LOG2(BAR_LOG2)) u_bar (
    .clk(clk), .rst_n(rst_n), .wr_hit(bar_wr),
    .be(cfg_be), .wdata(cfg_wdata), .bar(bar_w)
  );

  always_comb begin
    case (cfg_idx)
      IDX_W'(DW_ID):     rd_mux = {DEVICE_ID, VENDOR_ID};
      IDX_W'(DW_CMDSTS): rd_mux = {sts_w, cmd_w};
      IDX_W'(DW_CLASS):  rd_mux = {CLASS_CODE, REV_ID};
      IDX_W'(DW_HDR):    rd_mux = 32'h0;
      IDX_W'(DW_BAR):    rd_mux = bar_w;
      default:           rd_mux = 32'h0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (cfg_rd) rdata_q <= rd_mux;
  end

  assign cfg_rdata = rdata_q;
  assign mem_en    = cmd_w[1];
  assign perr_resp = cmd_w[6];
  assign serr_en   = cmd_w[8];
  assign bar_base  = bar_w;

  // R5
  devsel_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_idx == IDX_W'(DW_CMDSTS)) |=> (cfg_rdata[26:25] == 2'b01));
  // R10
  unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_idx > IDX_W'(DW_BAR)) |=> (cfg_rdata == 32'h0));
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd |=> $stable(cfg_rdata));
  // R8
  bar_read_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd && cfg_idx == IDX_W'(DW_BAR)) |=> (cfg_rdata[7:0] == 8'h0));
endmodule

// File: tb/pcfg_hdr_bench.sv
module pcfg_hdr_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  cfg_idx = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [31:0] cfg_rdata;
  logic        ev_tgt_abort = 1'b0;
  logic        ev_sys_err = 1'b0;
  logic        ev_parity_err = 1'b0;
  logic        mem_en, perr_resp, serr_en;
  logic [31:0] bar_base;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pcfg_hdr u_pcfg_hdr (
    .clk(clk), .rst_n(rst_n), .cfg_idx(cfg_idx), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_rdata(cfg_rdata),
    .ev_tgt_abort(ev_tgt_abort), .ev_sys_err(ev_sys_err), .ev_parity_err(ev_parity_err),
    .mem_en(mem_en), .perr_resp(perr_resp), .serr_en(serr_en), .bar_base(bar_base)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr_dw(input logic [5:0] idx, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_idx = idx; cfg_be = be; cfg_wdata = d; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic rd_dw(input logic [5:0] idx, output logic [31:0] d);
    @(negedge clk);
    cfg_idx = idx; cfg_rd = 1'b1;
    @(negedge clk);
    cfg_rd = 1'b0;
    d = cfg_rdata;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: ev_tgt_abort = 1'b1;
      1: ev_sys_err = 1'b1;
      default: ev_parity_err = 1'b1;
    endcase
    @(negedge clk);
    ev_tgt_abort = 1'b0; ev_sys_err = 1'b0; ev_parity_err = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd_dw(6'd1, d);
    chk("R4 cmd/status after reset", d, 32'h0200_0000);
    rd_dw(6'd4, d);
    chk("R4 BAR after reset", d, 32'h0);
    chk("R4 outputs after reset", {29'h0, mem_en, perr_resp, serr_en}, 32'h0);
  endtask

  task automatic t_ids();
    logic [31:0] d;
    rd_dw(6'd0, d);
    chk("R1 id dword", d, 32'h5A31_1B2C);
    n_run++;
    if (d[31:16] == 16'h0000 || d[31:16] == 16'hFFFF) begin
      n_fail++; $display("FAIL R1: device id %04h is a forbidden value (expected neither 0000 nor FFFF)", d[31:16]);
    end
    rd_dw(6'd2, d);
    chk("R2 class/revision", d, 32'h0180_0001);
    rd_dw(6'd3, d);
    chk("R2 header type dword", d, 32'h0);
  endtask

  task automatic t_cmd();
    logic [31:0] d;
    wr_dw(6'd1, 4'b0011, 32'h0000_FFFF);
    rd_dw(6'd1, d);
    chk("R3 command writable mask", d, 32'h0200_0142);
    chk("R3 control outputs set", {29'h0, mem_en, perr_resp, serr_en}, 32'h7);
    chk("R5 devsel timing code", {30'h0, d[26:25]}, 32'h1);
    wr_dw(6'd1, 4'b0011, 32'h0000_0040);
    chk("R3 control outputs partial", {29'h0, mem_en, perr_resp, serr_en}, 32'h2);
    wr_dw(6'd1, 4'b0011, 32'h0000_0000);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(0);
    rd_dw(6'd1, d);
    chk("R6 target abort bit 11", d, 32'h0A00_0000);
    pulse(1);
    pulse(2);
    rd_dw(6'd1, d);
    chk("R6 all sticky bits", d, 32'hCA00_0000);
    wr_dw(6'd1, 4'b1100, 32'h0000_0000);
    rd_dw(6'd1, d);
    chk("R7 writing zero keeps bits", d, 32'hCA00_0000);
    wr_dw(6'd1, 4'b1100, 32'h4000_0000);
    rd_dw(6'd1, d);
    chk("R7 w1c clears bit 14 only", d, 32'h8A00_0000);
    wr_dw(6'd1, 4'b0111, 32'hFFFF_0000);
    rd_dw(6'd1, d);
    chk("R9 clear needs lane 3 enable", d, 32'h8A00_0000);
    // event and clear in the same cycle: event wins
    @(negedge clk);
    cfg_idx = 6'd1; cfg_be = 4'b1000; cfg_wdata = 32'h0800_0000; cfg_wr = 1'b1; ev_tgt_abort = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0; cfg_be = '0; ev_tgt_abort = 1'b0;
    rd_dw(6'd1, d);
    chk("R7 event beats clear", d, 32'h8A00_0000);
    wr_dw(6'd1, 4'b1100, 32'hFFFF_0000);
    rd_dw(6'd1, d);
    chk("R7 clear all", d, 32'h0200_0000);
  endtask

  task automatic t_bar();
    logic [31:0] d;
    wr_dw(6'd4, 4'b1111, 32'hFFFF_FFFF);
    rd_dw(6'd4, d);
    chk("R8 size probe", d, 32'hFFFF_FF00);
    wr_dw(6'd4, 4'b1111, 32'hCD00_0000);
    rd_dw(6'd4, d);
    chk("R8 base readback", d, 32'hCD00_0000);
    chk("R8 bar_base port", bar_base, 32'hCD00_0000);
    wr_dw(6'd4, 4'b0100, 32'h1234_5678);
    rd_dw(6'd4, d);
    chk("R9 BAR lane 2 only", d, 32'hCD34_0000);
    wr_dw(6'd4, 4'b0001, 32'hFFFF_FFFF);
    rd_dw(6'd4, d);
    chk("R8 low byte stays zero", d, 32'hCD34_0000);
  endtask

  task automatic t_byte_en();
    logic [31:0] d;
    wr_dw(6'd1, 4'b0001, 32'hFFFF_FFFF);
    chk("R9 lane 0 only", {29'h0, mem_en, perr_resp, serr_en}, 32'h6);
    wr_dw(6'd1, 4'b0010, 32'hFFFF_FFFF);
    rd_dw(6'd1, d);
    chk("R9 lane 1 adds bit 8", d, 32'h0200_0142);
    wr_dw(6'd1, 4'b0011, 32'h0);
  endtask

  task automatic t_ro_unimpl();
    logic [31:0] d;
    wr_dw(6'd0, 4'b1111, 32'hFFFF_FFFF);
    wr_dw(6'd2, 4'b1111, 32'hFFFF_FFFF);
    wr_dw(6'd3, 4'b1111, 32'hFFFF_FFFF);
    wr_dw(6'd9, 4'b1111, 32'hFFFF_FFFF);
    rd_dw(6'd0, d);
    chk("R10 id unchanged", d, 32'h5A31_1B2C);
    rd_dw(6'd2, d);
    chk("R10 class unchanged", d, 32'h0180_0001);
    rd_dw(6'd3, d);
    chk("R10 header unchanged", d, 32'h0);
    rd_dw(6'd9, d);
    chk("R10 unimplemented dword 9", d, 32'h0);
    rd_dw(6'd63, d);
    chk("R10 unimplemented dword 63", d, 32'h0);
    rd_dw(6'd4, d);
    chk("R10 BAR untouched by other writes", d, 32'hCD34_0000);
  endtask

  task automatic t_rd_timing();
    logic [31:0] d;
    rd_dw(6'd0, d);
    @(negedge clk);
    cfg_idx = 6'd2;
    @(negedge clk);
    chk("R11 read data held without strobe", cfg_rdata, 32'h5A31_1B2C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ids();
    t_cmd();
    t_sticky();
    t_bar();
    t_byte_en();
    t_ro_unimpl();
    t_rd_timing();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not complete (expected completion)");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule